// File: doc/BRIEF.md
# Shared Parallel Bus Single-Cycle Target

This block is the slave side of a synchronous, shared, 32-bit bus on which address and data travel over the same wires. It watches every cycle on the bus. It captures the address and the command at the start of each cycle and decides whether the cycle belongs to it. Two address windows are recognised, one in memory space and one in I/O space. Each window is 16 words (64 bytes) long, and both windows map onto the same internal file of 16 registers.

When the cycle is its own, the target claims it with an active-low select line two clocks after the address phase. It then holds an active-low ready line high for a fixed number of wait states before it offers to complete the transfer. On a read, the target takes over the shared lines only after a turnaround clock has passed, and it drives them only while ready is asserted. On a write, the active-low byte enables pick which byte lanes of the addressed register are updated. Exactly one data word moves per cycle. When the transfer completes with the cycle-framing line already released, the target lets go of every line it drives.

Top module: `pbus_target`

## Requirements
- R1: After reset, `devsel_n` and `trdy_n` are 1, `ad_oe` is 0, and all 16 registers read as zero.
- R2: Command codes on `cbe_n` during the address phase are 4'b0110 for a memory read, 4'b0111 for a memory write, 4'b0010 for an I/O read and 4'b0011 for an I/O write. A memory command hits when address bits [31:6] equal `mem_base_hi`. An I/O command hits when bits [31:6] equal `io_base_hi`. Address bits [5:2] select the register, and both spaces reach the same register file.
- R3: An address outside the window of its own space, or any other command code, is never claimed. `devsel_n` stays 1, `trdy_n` stays 1 and no register changes.
- R4: On a hit, `devsel_n` goes to 0 right after the second rising edge that follows the edge where the address was captured.
- R5: `trdy_n` goes to 0 `WAIT_STATES` rising edges after `devsel_n` goes to 0. When `WAIT_STATES` is 0, both go to 0 after the same edge.
- R6: `ad_oe` is 0 during the turnaround clock after the address phase and at every moment when `trdy_n` is 1. On a read, `ad_oe` is 1 while `trdy_n` is 0, and `ad_out` carries the addressed register.
- R7: A write takes effect at the edge where `irdy_n` and `trdy_n` are both 0. For each lane i, the bits [8i+7:8i] of the register are loaded from `ad_in` only when `cbe_n[i]` is 0 in that data phase.
- R8: While `trdy_n` is 0 and `irdy_n` is 1, the target keeps `trdy_n` at 0 and holds `ad_out` steady until the initiator becomes ready.
- R9: When a transfer completes with `frame_n` at 1, `devsel_n` and `trdy_n` return to 1 and `ad_oe` returns to 0 right after that edge.
- R10: The address is captured only at the first edge where `frame_n` is 0 after it was 1. Values on `ad_in` during the data phase never alter which register is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low cycle framing from the initiator |
| irdy_n | input | 1 | Active-low initiator ready |
| cbe_n | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| ad_in | input | 32 | Address/data lines as seen by the target |
| mem_base_hi | input | 26 | Upper address bits of the memory-space window |
| io_base_hi | input | 26 | Upper address bits of the I/O-space window |
| ad_out | output | 32 | Read data the target presents |
| ad_oe | output | 1 | Target drives the address/data lines when 1 |
| devsel_n | output | 1 | Active-low claim of the current cycle |
| trdy_n | output | 1 | Active-low target ready |

## Verification
The hardest case to reach from the ports is a target that is already ready while the initiator is not. In that case ready must be held and the read data must not change for several clocks. The bench gets there by keeping the initiator ready line deasserted, with framing still active, for more clocks than the configured wait states. It then checks the ready latency, the stable read word and the release. Unclaimed cycles are the other awkward case, because they leave no trace on the select and ready lines. Each one is therefore followed by reads through the normal read path, which show that no register changed.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_WAIT,
        ST_DATA,
        ST_SKIP
    } tgt_state_e;

    localparam logic [3:0] CMD_IO_RD  = 4'b0010;
    localparam logic [3:0] CMD_IO_WR  = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;

    function automatic logic cmd_is_mem(input logic [3:0] c);
        return (c == CMD_MEM_RD) || (c == CMD_MEM_WR);
    endfunction

    function automatic logic cmd_is_io(input logic [3:0] c);
        return (c == CMD_IO_RD) || (c == CMD_IO_WR);
    endfunction

endpackage

// File: rtl/pbus_decode.sv
module pbus_decode #(
    parameter int ADDR_W    = 32,
    parameter int WORD_BITS = 4
) (
    input  logic [ADDR_W-1:2]           addr,
    input  logic [3:0]                  cmd,
    input  logic [ADDR_W-WORD_BITS-3:0] mem_base_hi,
    input  logic [ADDR_W-WORD_BITS-3:0] io_base_hi,
    output logic                        hit,
    output logic                        is_write,
    output logic [WORD_BITS-1:0]        word
);
    import pbus_pkg::*;

    localparam int WIN_BITS = WORD_BITS + 2;

    logic [ADDR_W-WIN_BITS-1:0] upper;
    logic                       mem_match;
    logic                       io_match;

    always_comb begin
        upper     = addr[ADDR_W-1:WIN_BITS];
        mem_match = cmd_is_mem(cmd) && (upper == mem_base_hi);
        io_match  = cmd_is_io(cmd)  && (upper == io_base_hi);
        hit       = mem_match || io_match;
        is_write  = cmd[0];
        word      = addr[WIN_BITS-1:2];
    end

endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile #(
    parameter int NWORDS = 16,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(NWORDS),
    localparam int NB    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [NB-1:0]     be,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [NWORDS];
    logic [DATA_W-1:0] mem_d [NWORDS];

    always_comb begin
        for (int w = 0; w < NWORDS; w++) begin
            mem_d[w] = mem_q[w];
            for (int b = 0; b < NB; b++) begin
                if (we && (addr == AW'(w)) && be[b]) begin
                    mem_d[w][b*8 +: 8] = wdata[b*8 +: 8];
                end
            end
        end
        rdata = mem_q[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORDS; w++) begin
                mem_q[w] <= '0;
            end
        end else begin
            for (int w = 0; w < NWORDS; w++) begin
                mem_q[w] <= mem_d[w];
            end
        end
    end

endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int WAIT_STATES = 2,
    localparam int CNT_W      = (WAIT_STATES < 2) ? 1 : $clog2(WAIT_STATES + 1),
    localparam int NB         = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [3:0]        cbe_n,
    input  logic [ADDR_W-1:0] ad_in,
    input  logic              dec_hit,
    input  logic              dec_write,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:2] lat_addr,
    output logic [3:0]        lat_cmd,
    output logic              wr_en,
    output logic [NB-1:0]     wr_be,
    output logic [DATA_W-1:0] wr_data,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              ad_oe,
    output logic [DATA_W-1:0] ad_out
);
    import pbus_pkg::*;

    typedef struct packed {
        tgt_state_e         st;
        logic               frame_prev;
        logic [ADDR_W-1:2]  addr;
        logic [3:0]         cmd;
        logic               wr;
        logic [CNT_W-1:0]   wcnt;
        logic               devsel_n;
        logic               trdy_n;
        logic               oe;
        logic [DATA_W-1:0]  dout;
    } ctrl_t;

    ctrl_t r_q;
    ctrl_t r_d;

    always_comb begin
        r_d            = r_q;
        r_d.frame_prev = frame_n;
        wr_en          = 1'b0;
        wr_be          = ~cbe_n[NB-1:0];
        wr_data        = ad_in[DATA_W-1:0];

        case (r_q.st)
            ST_IDLE: begin
                if (!frame_n && r_q.frame_prev) begin
                    r_d.addr = ad_in[ADDR_W-1:2];
                    r_d.cmd  = cbe_n;
                    r_d.st   = ST_ADDR1;
                end
            end
            ST_ADDR1: begin
                r_d.wr = dec_write;
                r_d.st = dec_hit ? ST_ADDR2 : ST_SKIP;
            end
            ST_ADDR2: begin
                r_d.devsel_n = 1'b0;
                if (WAIT_STATES == 0) begin
                    r_d.trdy_n = 1'b0;
                    r_d.oe     = !r_q.wr;
                    r_d.dout   = rd_data;
                    r_d.st     = ST_DATA;
                end else begin
                    r_d.wcnt = CNT_W'(WAIT_STATES);
                    r_d.st   = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (r_q.wcnt == CNT_W'(1)) begin
                    r_d.trdy_n = 1'b0;
                    r_d.oe     = !r_q.wr;
                    r_d.dout   = rd_data;
                    r_d.st     = ST_DATA;
                end else begin
                    r_d.wcnt = r_q.wcnt - CNT_W'(1);
                end
            end
            ST_DATA: begin
                if (!irdy_n) begin
                    wr_en        = r_q.wr;
                    r_d.devsel_n = 1'b1;
                    r_d.trdy_n   = 1'b1;
                    r_d.oe       = 1'b0;
                    r_d.dout     = '0;
                    r_d.st       = frame_n ? ST_IDLE : ST_SKIP;
                end
            end
            ST_SKIP: begin
                if (frame_n && irdy_n) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st         <= ST_IDLE;
            r_q.frame_prev <= 1'b1;
            r_q.addr       <= '0;
            r_q.cmd        <= '0;
            r_q.wr         <= 1'b0;
            r_q.wcnt       <= '0;
            r_q.devsel_n   <= 1'b1;
            r_q.trdy_n     <= 1'b1;
            r_q.oe         <= 1'b0;
            r_q.dout       <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lat_addr = r_q.addr;
    assign lat_cmd  = r_q.cmd;
    assign devsel_n = r_q.devsel_n;
    assign trdy_n   = r_q.trdy_n;
    assign ad_oe    = r_q.oe;
    assign ad_out   = r_q.dout;

endmodule

// File: rtl/pbus_target.sv
module pbus_target #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int NWORDS      = 16,
    parameter int WAIT_STATES = 2,
    localparam int WORD_BITS  = $clog2(NWORDS),
    localparam int BASE_W     = ADDR_W - WORD_BITS - 2,
    localparam int NB         = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic [3:0]        cbe_n,
    input  logic [ADDR_W-1:0] ad_in,
    input  logic [BASE_W-1:0] mem_base_hi,
    input  logic [BASE_W-1:0] io_base_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              devsel_n,
    output logic              trdy_n
);

    logic [ADDR_W-1:2]    lat_addr;
    logic [3:0]           lat_cmd;
    logic                 dec_hit;
    logic                 dec_write;
    logic [WORD_BITS-1:0] dec_word;
    logic                 wr_en;
    logic [NB-1:0]        wr_be;
    logic [DATA_W-1:0]    wr_data;
    logic [DATA_W-1:0]    rd_data;

    pbus_decode #(
        .ADDR_W    (ADDR_W),
        .WORD_BITS (WORD_BITS)
    ) u_decode (
        .addr        (lat_addr),
        .cmd         (lat_cmd),
        .mem_base_hi (mem_base_hi),
        .io_base_hi  (io_base_hi),
        .hit         (dec_hit),
        .is_write    (dec_write),
        .word        (dec_word)
    );

    pbus_regfile #(
        .NWORDS (NWORDS),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .be    (wr_be),
        .addr  (dec_word),
        .wdata (wr_data),
        .rdata (rd_data)
    );

    pbus_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .WAIT_STATES (WAIT_STATES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .cbe_n     (cbe_n),
        .ad_in     (ad_in),
        .dec_hit   (dec_hit),
        .dec_write (dec_write),
        .rd_data   (rd_data),
        .lat_addr  (lat_addr),
        .lat_cmd   (lat_cmd),
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .devsel_n  (devsel_n),
        .trdy_n    (trdy_n),
        .ad_oe     (ad_oe),
        .ad_out    (ad_out)
    );

endmodule

// File: rtl/pbus_target_chk.sv
module pbus_target_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_n,
    input logic              irdy_n,
    input logic              devsel_n,
    input logic              trdy_n,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out
);

    // R4: a claim appears three samples after framing was first seen low
    p_claim_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> !$past(frame_n, 3));

    // R5: ready is never offered without a claim
    p_trdy_claimed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    // R6: the shared lines are driven only while ready and claimed
    p_drive_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> (!trdy_n && !devsel_n));

    // R8: ready and data hold while the initiator waits
    p_hold_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && irdy_n) |=> (!trdy_n && $stable(ad_out)));

    // R9: everything is released after the final transfer
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n && !irdy_n && frame_n) |=> (devsel_n && trdy_n && !ad_oe));

endmodule

bind pbus_target pbus_target_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .ad_oe    (ad_oe),
    .ad_out   (ad_out)
);

// File: tb/pbus_target_test.sv
`timescale 1ns/1ps
module pbus_target_test;

    localparam int WS = 3;
    localparam logic [31:0] MEMB = 32'h4000_0000;
    localparam logic [31:0] IOB  = 32'h0000_1C40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic [3:0]  cbe_n = 4'hF;
    logic [31:0] ad_in = '0;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic        devsel_n;
    logic        trdy_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model [16];

    always #2 clk = ~clk;

    pbus_target #(.WAIT_STATES(WS)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_n     (frame_n),
        .irdy_n      (irdy_n),
        .cbe_n       (cbe_n),
        .ad_in       (ad_in),
        .mem_base_hi (MEMB[31:6]),
        .io_base_hi  (IOB[31:6]),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .devsel_n    (devsel_n),
        .trdy_n      (trdy_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle; checks claim latency, drive window and release.
    task automatic bus_cycle(input logic [3:0] cmd, input logic [31:0] addr,
                             input logic [3:0] be_n, input logic [31:0] wdata,
                             input int irdy_dly, input bit expect_claim,
                             output logic [31:0] rdata);
        int dev_at = -1;
        int rdy_at = -1;
        bit done = 0;
        bit is_wr = cmd[0];
        rdata = 'x;
        @(negedge clk);
        frame_n = 1'b0; ad_in = addr; cbe_n = cmd;
        @(negedge clk);
        cbe_n = be_n;
        ad_in = is_wr ? wdata : (MEMB + 32'h14);
        chk("R6 no drive after address phase", {31'd0, ad_oe}, 32'd0);
        for (int k = 0; k < 16 && !done; k++) begin
            if (k == 1) chk("R6 turnaround clock", {31'd0, ad_oe}, 32'd0);
            if (!devsel_n && dev_at < 0) dev_at = k;
            if (!trdy_n && rdy_at < 0) rdy_at = k;
            if (ad_oe && trdy_n) chk("R6 drive without ready", 32'd1, 32'd0);
            if (k == irdy_dly) begin irdy_n = 1'b0; frame_n = 1'b1; end
            if (!trdy_n && !irdy_n) begin
                if (!is_wr) begin
                    rdata = ad_out;
                    chk("R6 drive during read", {31'd0, ad_oe}, 32'd1);
                end
                @(negedge clk);
                chk("R9 release", {29'd0, devsel_n, trdy_n, ad_oe}, 32'b110);
                irdy_n = 1'b1;
                done = 1;
            end else begin
                @(negedge clk);
            end
        end
        if (!done) begin
            irdy_n = 1'b1; frame_n = 1'b1;
            @(negedge clk);
        end
        if (expect_claim) begin
            chk("R4 select latency", dev_at, 2);
            chk("R5 ready latency", rdy_at, 2 + WS);
        end else begin
            chk("R3 no claim", dev_at, -1);
            chk("R3 no ready", rdy_at, -1);
        end
    endtask

    task automatic wr_word(input logic [3:0] cmd, input logic [31:0] base, input int w,
                           input logic [3:0] be_n, input logic [31:0] d);
        logic [31:0] unused;
        bus_cycle(cmd, base + 32'(w * 4), be_n, d, 0, 1, unused);
        for (int b = 0; b < 4; b++)
            if (!be_n[b]) model[w][b*8 +: 8] = d[b*8 +: 8];
    endtask

    task automatic rd_check(input string tag, input logic [3:0] cmd, input logic [31:0] base,
                            input int w);
        logic [31:0] r;
        bus_cycle(cmd, base + 32'(w * 4), 4'h0, 32'h0, 0, 1, r);
        chk(tag, r, model[w]);
    endtask

    task automatic t_reset;
        chk("R1 reset outputs", {29'd0, devsel_n, trdy_n, ad_oe}, 32'b110);
        rd_check("R1 reset register zero", pbus_pkg::CMD_MEM_RD, MEMB, 0);
        rd_check("R1 reset register zero", pbus_pkg::CMD_IO_RD, IOB, 15);
    endtask

    task automatic t_fill;
        for (int w = 0; w < 16; w++)
            wr_word(pbus_pkg::CMD_MEM_WR, MEMB, w, 4'h0, 32'hA500_0000 ^ (32'(w) * 32'h0101_0101));
        for (int w = 0; w < 16; w++) begin
            if (w % 2 == 0) rd_check("R2 memory readback", pbus_pkg::CMD_MEM_RD, MEMB, w);
            else            rd_check("R2 I/O alias readback", pbus_pkg::CMD_IO_RD, IOB, w);
        end
        wr_word(pbus_pkg::CMD_IO_WR, IOB, 9, 4'h0, 32'h5A5A_0909);
        rd_check("R2 I/O write memory read", pbus_pkg::CMD_MEM_RD, MEMB, 9);
    endtask

    task automatic t_lanes;
        wr_word(pbus_pkg::CMD_MEM_WR, MEMB, 6, 4'h0, 32'hFFFF_FFFF);
        wr_word(pbus_pkg::CMD_MEM_WR, MEMB, 6, 4'b1010, 32'h1122_3344);
        rd_check("R7 lanes 0 and 2", pbus_pkg::CMD_MEM_RD, MEMB, 6);
        wr_word(pbus_pkg::CMD_MEM_WR, MEMB, 6, 4'b0111, 32'h9900_0000);
        rd_check("R7 lane 3 only", pbus_pkg::CMD_MEM_RD, MEMB, 6);
        wr_word(pbus_pkg::CMD_MEM_WR, MEMB, 6, 4'b1111, 32'h0000_0000);
        rd_check("R7 no lanes", pbus_pkg::CMD_MEM_RD, MEMB, 6);
    endtask

    task automatic t_latch;
        wr_word(pbus_pkg::CMD_MEM_WR, MEMB, 3, 4'h0, MEMB + 32'h14);
        rd_check("R10 target word written", pbus_pkg::CMD_MEM_RD, MEMB, 3);
        rd_check("R10 data-phase address ignored", pbus_pkg::CMD_MEM_RD, MEMB, 5);
    endtask

    task automatic t_miss;
        logic [31:0] r;
        bus_cycle(pbus_pkg::CMD_MEM_WR, MEMB + 32'h40 + 32'h8, 4'h0, 32'hDEAD_0001, 0, 0, r);
        bus_cycle(pbus_pkg::CMD_IO_WR, MEMB + 32'h8, 4'h0, 32'hDEAD_0002, 0, 0, r);
        bus_cycle(4'b1011, MEMB + 32'h8, 4'h0, 32'hDEAD_0003, 0, 0, r);
        bus_cycle(pbus_pkg::CMD_MEM_RD, IOB + 32'h8, 4'h0, 32'h0, 0, 0, r);
        rd_check("R3 ignored writes left word", pbus_pkg::CMD_MEM_RD, MEMB, 2);
    endtask

    task automatic t_wait;
        logic [31:0] r;
        bus_cycle(pbus_pkg::CMD_MEM_RD, MEMB + 32'h30, 4'h0, 32'h0, WS + 4, 1, r);
        chk("R8 read after initiator wait", r, model[12]);
        bus_cycle(pbus_pkg::CMD_IO_WR, IOB + 32'h34, 4'b0000, 32'hC0DE_1313, WS + 3, 1, r);
        model[13] = 32'hC0DE_1313;
        rd_check("R8 write after initiator wait", pbus_pkg::CMD_MEM_RD, MEMB, 13);
    endtask

    initial begin
        for (int w = 0; w < 16; w++) model[w] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_lanes();
        t_latch();
        t_miss();
        t_wait();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule